// File: doc/BRIEF.md
# Two-Wire Serial Slave with Busy Polling

This block is the bus front end of a small register-controlled device, such as a digitally set trim element. It watches the serial clock and data lines of a two-wire bus and passes both through a synchroniser clocked by the system clock. It finds start and stop conditions and shifts in an address byte and an instruction byte. For writes it also shifts in a 10-bit data word, carried in two bytes. It drives an open-drain enable to pull the data line low, both for its acknowledges and for read data.

An address byte is accepted only when three things hold: its upper nibble equals the fixed device type, the next bit is zero, and the two bits after that equal the two strap pins. While the back end reports a nonvolatile write in progress, the slave withholds the address acknowledge. A master can therefore poll with address bytes until one is acknowledged. The back end sees a single-cycle command strobe at each stop. Along with the strobe come the read/write bit, the instruction byte, the assembled word and a flag that says whether a complete word was received. For reads the back end supplies a 10-bit value, which the slave shifts out as two bytes.

Top module: `twsl_slave`

## Requirements
- R1: After reset `sda_oe_o` is 0 and `cmd_stb_o` is 0.
- R2: SDA falling while SCL is high is a start. SDA rising while SCL is high is a stop. A start at any point, including in the middle of a byte, drops the current transfer and begins address reception again.
- R3: The first byte after a start is taken MSB first. It is accepted when bits 7:4 equal 4'b0101, bit 3 is 0 and bits 2:1 equal `strap_i[1:0]`. Bit 0 is the direction: 1 means read. On acceptance the slave pulls SDA low during the ninth clock.
- R4: An address byte that does not match gets no acknowledge. The slave then leaves SDA released for every later byte until the next start, and the stop that ends that transfer gives no strobe.
- R5: If `busy_i` is high when the address byte ends, a matching address gets no acknowledge.
- R6: In a write the slave acknowledges the instruction byte and the two data bytes that follow it. Any byte after the second data byte gets no acknowledge.
- R7: The 10-bit word is carried MSB first. In the first data byte, bits 1:0 are word bits 9:8 and bits 7:2 are ignored. The second data byte is word bits 7:0.
- R8: At a stop that ends a transfer whose instruction byte was acknowledged, `cmd_stb_o` is high for exactly one cycle. It carries `cmd_rw_o`, `cmd_ins_o` and `cmd_dvld_o`. `cmd_dvld_o` is 1 only when both data bytes of a write were acknowledged, and in that case `cmd_data_o` holds the word.
- R9: In a read, after the instruction acknowledge, the slave sends {6'b0, `rd_data_i[9:8]`} and then `rd_data_i[7:0]`. `rd_data_i` is captured when the first of these bytes begins. SDA driven by the slave changes only while SCL is low.
- R10: In a read, an acknowledge from the master (SDA low on the ninth clock) after the first data byte makes the slave send the second byte. A master not-acknowledge makes the slave release SDA and send nothing more until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Serial data line as seen on the bus, asynchronous |
| strap_i | input | 2 | Address strap pins compared with address bits 2:1 |
| busy_i | input | 1 | Back end busy with a nonvolatile write |
| rd_data_i | input | 10 | Word returned to the bus on reads |
| sda_oe_o | output | 1 | Open-drain enable, 1 pulls SDA low |
| cmd_stb_o | output | 1 | One-cycle command strobe at stop |
| cmd_rw_o | output | 1 | Direction bit of the last accepted address |
| cmd_ins_o | output | 8 | Last accepted instruction byte |
| cmd_data_o | output | 10 | Last assembled write word |
| cmd_dvld_o | output | 1 | Word received complete in this transfer |

## Verification
A wrong byte counter or transfer state shows up at the bus within one byte time: an acknowledge lands on the wrong ninth clock, or a read bit is shifted into the wrong position, and the master's next sample catches it. A wrong match or busy decision shows up at the first ninth clock after the address. A wrong record of whether an instruction was taken shows up only at the stop, as a strobe that is missing, extra or carries the wrong fields. The bench therefore keeps a queue of the strobes it expects and compares the strobe output on every clock. It checks acknowledges and read bits at the middle of each SCL high phase.

// File: rtl/twsl_pkg.sv
package twsl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_MACK,
      ST_MGO
   } twsl_state_e;

endpackage

// File: rtl/twsl_sync.sv
module twsl_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 1) begin : g_chk
      $error("twsl_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_one
      logic q_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q_r <= RST_VAL;
         else        q_r <= d_i;
      end
      assign q_o = q_r;
   end else begin : g_chain
      logic [STAGES-1:0] chain_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_r <= {STAGES{RST_VAL}};
         else        chain_r <= {chain_r[STAGES-2:0], d_i};
      end
      assign q_o = chain_r[STAGES-1];
   end

endmodule

// File: rtl/twsl_busev.sv
module twsl_busev (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s_i,
   input  logic sda_s_i,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);

   logic scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s_i;
         sda_p <= sda_s_i;
      end
   end

   assign scl_rise_o = scl_s_i & ~scl_p;
   assign scl_fall_o = ~scl_s_i & scl_p;
   assign start_o    = scl_s_i & scl_p & sda_p & ~sda_s_i;
   assign stop_o     = scl_s_i & scl_p & ~sda_p & sda_s_i;

endmodule

// File: rtl/twsl_slave.sv
module twsl_slave
   import twsl_pkg::*;
#(
   parameter int         WORD_W      = 10,
   parameter int         SYNC_STAGES = 2,
   parameter logic [3:0] DEV_TYPE    = 4'b0101
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [1:0]        strap_i,
   input  logic              busy_i,
   input  logic [WORD_W-1:0] rd_data_i,
   output logic              sda_oe_o,
   output logic              cmd_stb_o,
   output logic              cmd_rw_o,
   output logic [7:0]        cmd_ins_o,
   output logic [WORD_W-1:0] cmd_data_o,
   output logic              cmd_dvld_o
);

   localparam int HI_W     = WORD_W - 8;
   localparam int LINES    = 2;
   localparam int IDX_ADDR = 0;
   localparam int IDX_INS  = 1;
   localparam int IDX_DHI  = 2;
   localparam int IDX_DLO  = 3;

   if (WORD_W < 9 || WORD_W > 16) begin : g_chk_w
      $error("twsl_slave: WORD_W must be within 9..16");
   end
   if (SYNC_STAGES < 2) begin : g_chk_s
      $error("twsl_slave: SYNC_STAGES must be at least 2");
   end

   // synchronise both bus lines: index 0 = clock, index 1 = data
   logic [LINES-1:0] line_raw, line_s;
   assign line_raw = {sda_i, scl_i};

   for (genvar g = 0; g < LINES; g++) begin : g_sync
      twsl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d_i   (line_raw[g]),
         .q_o   (line_s[g])
      );
   end

   logic scl_s, sda_s;
   assign scl_s = line_s[0];
   assign sda_s = line_s[1];

   logic scl_rise, scl_fall, start_w, stop_w;

   twsl_busev u_busev (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_s_i    (scl_s),
      .sda_s_i    (sda_s),
      .scl_rise_o (scl_rise),
      .scl_fall_o (scl_fall),
      .start_o    (start_w),
      .stop_o     (stop_w)
   );

   // read word split into the two transmitted bytes
   logic [7:0] rd_hi_w, rd_lo_w;
   if (HI_W == 8) begin : g_hi_full
      assign rd_hi_w = rd_data_i[WORD_W-1:8];
   end else begin : g_hi_pad
      assign rd_hi_w = {{(8-HI_W){1'b0}}, rd_data_i[WORD_W-1:8]};
   end
   assign rd_lo_w = rd_data_i[7:0];

   twsl_state_e      state_q;
   logic [3:0]       cnt_q;
   logic [2:0]       idx_q;
   logic [7:0]       rx_sh_q;
   logic [7:0]       tx_sh_q;
   logic [7:0]       tx_lo_q;
   logic             tx_second_q;
   logic             oe_q;
   logic             stb_q;
   logic             rw_q;
   logic             ins_seen_q;
   logic [7:0]       ins_q;
   logic [HI_W-1:0]  hi_q;
   logic [WORD_W-1:0] data_q;
   logic             dvld_q;

   // acceptance of the byte just completed
   logic accept_w;
   always_comb begin
      case (idx_q)
         3'(IDX_ADDR): accept_w = (rx_sh_q[7:4] == DEV_TYPE) && !rx_sh_q[3] &&
                                  (rx_sh_q[2:1] == strap_i) && !busy_i;
         3'(IDX_INS):  accept_w = 1'b1;
         3'(IDX_DHI),
         3'(IDX_DLO):  accept_w = !rw_q;
         default:      accept_w = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         cnt_q       <= '0;
         idx_q       <= '0;
         rx_sh_q     <= '0;
         tx_sh_q     <= '0;
         tx_lo_q     <= '0;
         tx_second_q <= 1'b0;
         oe_q        <= 1'b0;
         stb_q       <= 1'b0;
         rw_q        <= 1'b0;
         ins_seen_q  <= 1'b0;
         ins_q       <= '0;
         hi_q        <= '0;
         data_q      <= '0;
         dvld_q      <= 1'b0;
      end else begin
         stb_q <= 1'b0;
         if (start_w) begin
            state_q    <= ST_RX;
            cnt_q      <= '0;
            idx_q      <= '0;
            oe_q       <= 1'b0;
            ins_seen_q <= 1'b0;
            dvld_q     <= 1'b0;
         end else if (stop_w) begin
            stb_q      <= ins_seen_q;
            ins_seen_q <= 1'b0;
            state_q    <= ST_IDLE;
            oe_q       <= 1'b0;
         end else begin
            case (state_q)
               ST_RX: begin
                  if (scl_rise && cnt_q != 4'd8) begin
                     rx_sh_q <= {rx_sh_q[6:0], sda_s};
                     cnt_q   <= cnt_q + 4'd1;
                  end else if (scl_fall && cnt_q == 4'd8) begin
                     cnt_q <= '0;
                     if (accept_w) begin
                        oe_q    <= 1'b1;
                        state_q <= ST_ACK;
                        idx_q   <= idx_q + 3'd1;
                        case (idx_q)
                           3'(IDX_ADDR): rw_q <= rx_sh_q[0];
                           3'(IDX_INS): begin
                              ins_q      <= rx_sh_q;
                              ins_seen_q <= 1'b1;
                           end
                           3'(IDX_DHI):  hi_q <= rx_sh_q[HI_W-1:0];
                           default: begin
                              data_q <= {hi_q, rx_sh_q};
                              dvld_q <= 1'b1;
                           end
                        endcase
                     end else begin
                        oe_q    <= 1'b0;
                        state_q <= ST_IDLE;
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     if (rw_q && idx_q >= 3'(IDX_DHI)) begin
                        tx_sh_q     <= rd_hi_w;
                        tx_lo_q     <= rd_lo_w;
                        tx_second_q <= 1'b0;
                        oe_q        <= ~rd_hi_w[7];
                        cnt_q       <= 4'd1;
                        state_q     <= ST_TX;
                     end else begin
                        oe_q    <= 1'b0;
                        cnt_q   <= '0;
                        state_q <= ST_RX;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (cnt_q == 4'd8) begin
                        oe_q    <= 1'b0;
                        state_q <= ST_MACK;
                     end else begin
                        tx_sh_q <= {tx_sh_q[6:0], 1'b0};
                        oe_q    <= ~tx_sh_q[6];
                        cnt_q   <= cnt_q + 4'd1;
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) begin
                     if (!sda_s && !tx_second_q) state_q <= ST_MGO;
                     else                        state_q <= ST_IDLE;
                  end
               end
               ST_MGO: begin
                  if (scl_fall) begin
                     tx_sh_q     <= tx_lo_q;
                     oe_q        <= ~tx_lo_q[7];
                     tx_second_q <= 1'b1;
                     cnt_q       <= 4'd1;
                     state_q     <= ST_TX;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe_o   = oe_q;
   assign cmd_stb_o  = stb_q;
   assign cmd_rw_o   = rw_q;
   assign cmd_ins_o  = ins_q;
   assign cmd_data_o = data_q;
   assign cmd_dvld_o = dvld_q;

   // ---------------- assertions ----------------
   AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      start_w |=> (state_q == ST_RX && cnt_q == 4'd0 && !oe_q)); // R2

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) |-> !oe_q); // R4

   AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RX && idx_q == 3'(IDX_ADDR) && cnt_q == 4'd8 && scl_fall && busy_i)
         |=> !oe_q); // R5

   AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      stb_q |=> !stb_q); // R8

   AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe_q) |-> !scl_s); // R9

endmodule

// File: tb/twsl_slave_tb_top.sv
module twsl_slave_tb_top;

   localparam int H = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic [1:0] strap = 2'b10;
   logic       busy = 1'b0;
   logic [9:0] rd_data = 10'h2A5;
   logic       sda_oe;
   logic       cmd_stb, cmd_rw, cmd_dvld;
   logic [7:0] cmd_ins;
   logic [9:0] cmd_data;
   logic       sda_bus;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   assign sda_bus = sda_m & ~sda_oe;

   twsl_slave dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_m),
      .sda_i      (sda_bus),
      .strap_i    (strap),
      .busy_i     (busy),
      .rd_data_i  (rd_data),
      .sda_oe_o   (sda_oe),
      .cmd_stb_o  (cmd_stb),
      .cmd_rw_o   (cmd_rw),
      .cmd_ins_o  (cmd_ins),
      .cmd_data_o (cmd_data),
      .cmd_dvld_o (cmd_dvld)
   );

   typedef struct {
      bit       rw;
      bit [7:0] ins;
      bit [9:0] data;
      bit       dvld;
   } exp_t;

   exp_t exp_q[$];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // reference: every clock, a strobe must match the oldest expected command
   always @(negedge clk) begin
      if (rst_n && cmd_stb) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R8 unexpected strobe", 1, 0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(cmd_rw == e.rw, "R8 rw", int'(cmd_rw), int'(e.rw));
            chk(cmd_ins == e.ins, "R8 instruction", int'(cmd_ins), int'(e.ins));
            chk(cmd_dvld == e.dvld, "R8 data valid", int'(cmd_dvld), int'(e.dvld));
            if (e.dvld)
               chk(cmd_data == e.data, "R7 assembled word", int'(cmd_data), int'(e.data));
         end
      end
   end

   task automatic w(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; w(H);
      scl_m = 1'b1; w(H);
      sda_m = 1'b0; w(H);
      scl_m = 1'b0; w(H);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; w(H);
      scl_m = 1'b1; w(H);
      sda_m = 1'b1; w(H);
   endtask

   task automatic put_bit(input bit b);
      sda_m = b;    w(H);
      scl_m = 1'b1; w(H);
      scl_m = 1'b0; w(H);
   endtask

   task automatic put_byte(input bit [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) put_bit(b[i]);
      sda_m = 1'b1; w(H);
      scl_m = 1'b1; w(H/2);
      ack = !sda_bus;
      w(H/2);
      scl_m = 1'b0; w(H);
   endtask

   task automatic get_byte(output bit [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         w(H);
         scl_m = 1'b1; w(H/2);
         b[i] = sda_bus;
         w(H/2);
         scl_m = 1'b0;
      end
      w(H);
   endtask

   task automatic put_mack(input bit ack);
      sda_m = !ack; w(H);
      scl_m = 1'b1; w(H);
      scl_m = 1'b0; w(H);
   endtask

   task automatic push(input bit rw, input bit [7:0] ins, input bit [9:0] data, input bit dvld);
      exp_t e;
      e.rw = rw; e.ins = ins; e.data = data; e.dvld = dvld;
      exp_q.push_back(e);
   endtask

   initial begin
      bit       a;
      bit [7:0] b;
      w(4);
      chk(sda_oe == 1'b0, "R1 oe at reset", int'(sda_oe), 0);
      chk(cmd_stb == 1'b0, "R1 strobe at reset", int'(cmd_stb), 0);
      rst_n = 1'b1;
      w(10);

      // full write: address 0101_0_10_0, instruction, two data bytes
      bus_start();
      put_byte(8'h54, a); chk(a, "R3 address ack", int'(a), 1);
      put_byte(8'hC4, a); chk(a, "R6 instruction ack", int'(a), 1);
      put_byte(8'hFE, a); chk(a, "R6 first data ack", int'(a), 1);
      put_byte(8'h5C, a); chk(a, "R6 second data ack", int'(a), 1);
      push(1'b0, 8'hC4, 10'h25C, 1'b1);  // R7: upper six bits of 8'hFE ignored
      bus_stop();
      w(20);

      // wrong type nibble
      bus_start();
      put_byte(8'h74, a); chk(!a, "R4 type mismatch no ack", int'(a), 0);
      put_byte(8'hC4, a); chk(!a, "R4 ignored after mismatch", int'(a), 0);
      bus_stop();
      w(20);

      // wrong strap bits
      bus_start();
      put_byte(8'h52, a); chk(!a, "R4 strap mismatch no ack", int'(a), 0);
      bus_stop();

      // bit 3 set
      bus_start();
      put_byte(8'h5C, a); chk(!a, "R3 bit3 must be zero", int'(a), 0);
      bus_stop();

      // busy polling
      busy = 1'b1;
      bus_start();
      put_byte(8'h54, a); chk(!a, "R5 busy no ack", int'(a), 0);
      bus_stop();
      busy = 1'b0;
      bus_start();
      put_byte(8'h54, a); chk(a, "R5 ack once idle", int'(a), 1);
      put_byte(8'hE4, a); chk(a, "R6 two-byte instruction ack", int'(a), 1);
      push(1'b0, 8'hE4, 10'h0, 1'b0);
      bus_stop();
      w(20);

      // read with master ack then not-ack
      rd_data = 10'h2A5;
      bus_start();
      put_byte(8'h55, a); chk(a, "R3 read address ack", int'(a), 1);
      put_byte(8'hA0, a); chk(a, "R6 read instruction ack", int'(a), 1);
      get_byte(b); chk(b == 8'h02, "R9 read high byte", int'(b), 8'h02);
      put_mack(1'b1);
      get_byte(b); chk(b == 8'hA5, "R10 read low byte", int'(b), 8'hA5);
      put_mack(1'b0);
      push(1'b1, 8'hA0, 10'h0, 1'b0);
      bus_stop();
      w(20);

      // read ended by not-ack after first byte
      rd_data = 10'h17E;
      bus_start();
      put_byte(8'h55, a);
      put_byte(8'h80, a);
      get_byte(b); chk(b == 8'h01, "R9 read high byte 2", int'(b), 8'h01);
      put_mack(1'b0);
      get_byte(b); chk(b == 8'hFF, "R10 silent after nack", int'(b), 8'hFF);
      push(1'b1, 8'h80, 10'h0, 1'b0);
      bus_stop();
      w(20);

      // extra byte after the word is not acknowledged
      bus_start();
      put_byte(8'h54, a);
      put_byte(8'hC8, a);
      put_byte(8'h01, a);
      put_byte(8'h33, a);
      put_byte(8'h99, a); chk(!a, "R6 no ack past word", int'(a), 0);
      push(1'b0, 8'hC8, 10'h133, 1'b1);
      bus_stop();
      w(20);

      // start in mid byte restarts address reception
      bus_start();
      put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
      bus_start();
      put_byte(8'h54, a); chk(a, "R2 restart address ack", int'(a), 1);
      put_byte(8'hCC, a);
      put_byte(8'h03, a);
      put_byte(8'h00, a);
      push(1'b0, 8'hCC, 10'h300, 1'b1);
      bus_stop();
      w(20);

      chk(exp_q.size() == 0, "R8 all strobes seen", exp_q.size(), 0);
      chk(sda_oe == 1'b0, "R4 released when idle", int'(sda_oe), 0);
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (150000) @(posedge clk);
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
         end
      join_any
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule